// File: doc/BRIEF.md
# Supervisory Watchdog with Reset-Cause Register

This block watches a processor from reset release onward. It is running as soon as reset ends. A 16-bit up-counter advances on a prescaled tick, and software must restart it before it wraps. When the counter wraps, the block holds an internal reset request and an active-low reset output for a fixed number of clocks. It then restarts the counter and re-arms itself.

Software can stop the watchdog only during the start-up window, before the end-of-initialization strobe. A 16-bit control word holds the reload byte and the tick-rate select. It also exposes five read-only flags that record why the system was last reset. Each flag has its own set and clear events, and several flags may be set at once.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, the block is reset as follows: the counter becomes 0000h, the watchdog becomes active (`wd_active`=1), `rst_req`=0, `rst_out_n`=1, the reload byte becomes 00h and the select bit becomes 0.
- R2: A `dis_stb` stops the counter (`wd_active`=0, count frozen) only if no `einit_stb` has been taken since the last reset. After an `einit_stb` it is ignored. Both a hardware reset and the end of a watchdog reset window reopen the start-up window.
- R3: The counter advances by one on each prescaler tick. The prescaler is a 7-bit divider that counts from 0 at reset release. With select=0, a tick occurs when the divider value is odd (every 2 clocks). With select=1, a tick occurs when the divider value is 127 (every 128 clocks).
- R4: A `svc_stb` loads the counter with {reload, 00h}. If a service and an overflow fall on the same clock, the service wins and no reset is raised.
- R5: When a tick finds the counter at FFFFh, the counter wraps to 0000h. From the next cycle, `rst_req`=1 and `rst_out_n`=0 for exactly HOLD_CYCLES clocks (default 4). The counter then holds {reload, 00h} and runs again.
- R6: The control word reads {reload[15:8], 00b[7:6], power-on[5], long-hw[4], short-hw[3], software[2], watchdog[1], select[0]}. A write updates only bits 15:8 and bit 0.
- R7: The watchdog flag (bit 1) is set by an overflow. It is cleared by a taken service or by a hardware reset.
- R8: `sw_rst_stb` sets the software flag (bit 2). During reset, bits 5:3 load from `cause_por`, `cause_long` and `cause_short`. `einit_stb` clears bits 5:2 and leaves bit 1 and bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cause_short | input | 1 | Short external reset cause, captured during reset |
| cause_long | input | 1 | Long external reset cause, captured during reset |
| cause_por | input | 1 | Power-on cause, captured during reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word read value |
| svc_stb | input | 1 | Service strobe |
| dis_stb | input | 1 | Disable strobe |
| einit_stb | input | 1 | End-of-initialization strobe |
| sw_rst_stb | input | 1 | Software-reset strobe |
| cnt | output | 16 | Current counter value |
| wd_active | output | 1 | Counter is enabled |
| rst_req | output | 1 | Internal reset request |
| rst_out_n | output | 1 | Active-low external reset output |

## Verification
A wrong prescaler phase or a wrong count shows up as a reset window that opens one or more clocks early or late. The bench predicts the exact opening edge from the clock count since reset release. A wrong hold counter shows as a reset window of the wrong length. A wrong reload path shows in the count value on the first sample after a service or after the window closes. A wrong flag shows in the control word on the first sample after the strobe that should have changed it.

// File: rtl/wdog_pkg.sv
// Package: shared layout of the watchdog control word.
// Assumes a 16-bit word with the reload byte in the upper half.
package wdog_pkg;
    localparam int REG_W      = 16;
    localparam int RELOAD_LSB = 8;
    localparam int REL_W      = REG_W - RELOAD_LSB;
    localparam int BIT_FSEL   = 0;

    // Reset-cause flags; the packed order maps onto word bits 5..1.
    typedef struct packed {
        logic por;
        logic lng;
        logic shrt;
        logic sw;
        logic wdt;
    } cause_t;
endpackage

// File: rtl/wdog_prescaler.sv
// Module: free-running divider that yields a one-cycle count-enable tick.
// Assumes the divider restarts from zero on reset. The fast tick is every
// 2 clocks and the slow tick is every 2**PRE_W clocks.
module wdog_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsel,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Pick the fast or the slow tick.
    always_comb tick = fsel ? (&pre_q) : pre_q[0];

    // R3: the divider never ticks on two clocks in a row.
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdog_core.sv
// Module: watchdog counter, reset window and start-up disable window.
// Assumes single-cycle strobes. The service strobe beats overflow, and all
// strobes are ignored while the reset window is open.
module wdog_core #(
    parameter int CNT_W       = 16,
    parameter int REL_W       = 8,
    parameter int HOLD_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [REL_W-1:0] reload,
    input  logic             svc_stb,
    input  logic             dis_stb,
    input  logic             einit_stb,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             hold_on,
    output logic             ovf,
    output logic             svc_take
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [HW-1:0]    hold_q;
    logic             en_q;
    logic             done_q;
    logic [CNT_W-1:0] reload_word;

    // Reload value placed in the counter's upper bits.
    always_comb reload_word = {reload, {(CNT_W-REL_W){1'b0}}};

    // Decode the window, service-accept and overflow events.
    always_comb begin
        hold_on  = (hold_q != '0);
        svc_take = svc_stb && !hold_on;
        ovf      = tick && en_q && !hold_on && !svc_stb && (cnt_q == '1);
    end

    // Counter and reset-window sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (hold_on) begin
            hold_q <= hold_q - 1'b1;
            if (hold_q == HW'(1)) cnt_q <= reload_word;
        end else if (svc_stb) begin
            cnt_q <= reload_word;
        end else if (ovf) begin
            cnt_q  <= '0;
            hold_q <= HW'(HOLD_CYCLES);
        end else if (tick && en_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Enable and start-up window tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            done_q <= 1'b0;
        end else if (hold_on) begin
            if (hold_q == HW'(1)) begin
                en_q   <= 1'b1;
                done_q <= 1'b0;
            end
        end else begin
            if (einit_stb)            done_q <= 1'b1;
            if (dis_stb && !done_q)   en_q   <= 1'b0;
        end
    end

    always_comb begin
        cnt    = cnt_q;
        active = en_q;
    end

    // R5: an overflow opens the full reset window on the next cycle.
    assert_window_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (hold_q == HW'(HOLD_CYCLES)));
    // R4: a taken service loads the reload word.
    assert_service_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_take |=> (cnt_q == $past(reload_word)));
    // R2: once initialization has ended, the enable cannot drop.
    assert_disable_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && en_q) |=> en_q);
    // R2: a disabled counter holds its value.
    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !hold_on && !svc_stb) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_flags.sv
// Module: reset-cause flags with independent set and clear events.
// Assumes the cause inputs are stable while rst_n is low.
module wdog_flags
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cause_short,
    input  logic   cause_long,
    input  logic   cause_por,
    input  logic   sw_stb,
    input  logic   einit_stb,
    input  logic   ovf,
    input  logic   svc_take,
    output cause_t flags
);
    cause_t f_q;

    // Capture the causes in reset, then apply the set and clear events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.wdt  <= 1'b0;
            f_q.sw   <= 1'b0;
            f_q.shrt <= cause_short;
            f_q.lng  <= cause_long;
            f_q.por  <= cause_por;
        end else begin
            if (ovf)           f_q.wdt <= 1'b1;
            else if (svc_take) f_q.wdt <= 1'b0;
            if (sw_stb)         f_q.sw <= 1'b1;
            else if (einit_stb) f_q.sw <= 1'b0;
            if (einit_stb) begin
                f_q.shrt <= 1'b0;
                f_q.lng  <= 1'b0;
                f_q.por  <= 1'b0;
            end
        end
    end

    always_comb flags = f_q;

    // R7: a taken service leaves the watchdog flag clear.
    assert_wdt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_take |=> !f_q.wdt);
    // R8: end-of-initialization clears the cause flags.
    assert_einit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (einit_stb && !sw_stb) |=> (!f_q.sw && !f_q.shrt && !f_q.lng && !f_q.por));
    // R7: an overflow sets the watchdog flag.
    assert_wdt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> f_q.wdt);
endmodule

// File: rtl/wdog_ctrl_reg.sv
// Module: writable fields of the control word (select bit and reload byte).
// Assumes the flag bits are read-only and composed by the parent.
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             fsel,
    output logic [REL_W-1:0] reload
);
    logic unused_wr_bits;

    // Hold the writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel   <= 1'b0;
            reload <= '0;
        end else if (wr_en) begin
            fsel   <= wr_data[BIT_FSEL];
            reload <= wr_data[REG_W-1:RELOAD_LSB];
        end
    end

    // Bits 7:1 carry no storage.
    always_comb unused_wr_bits = ^wr_data[RELOAD_LSB-1:BIT_FSEL+1];
endmodule

// File: rtl/wdog_supervisor.sv
// Module: top of the watchdog. It joins the prescaler, the counter core,
// the cause flags and the control word.
// Assumes a synchronous active-low hardware reset and single-cycle strobes.
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 7,
    parameter int HOLD_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cause_short,
    input  logic             cause_long,
    input  logic             cause_por,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             svc_stb,
    input  logic             dis_stb,
    input  logic             einit_stb,
    input  logic             sw_rst_stb,
    output logic [CNT_W-1:0] cnt,
    output logic             wd_active,
    output logic             rst_req,
    output logic             rst_out_n
);
    logic             fsel;
    logic [REL_W-1:0] reload;
    logic             tick;
    logic             hold_on;
    logic             ovf;
    logic             svc_take;
    cause_t           flags;

    wdog_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fsel(fsel), .reload(reload)
    );

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .fsel(fsel), .tick(tick)
    );

    wdog_core #(.CNT_W(CNT_W), .REL_W(REL_W), .HOLD_CYCLES(HOLD_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
        .svc_stb(svc_stb), .dis_stb(dis_stb), .einit_stb(einit_stb),
        .cnt(cnt), .active(wd_active), .hold_on(hold_on), .ovf(ovf),
        .svc_take(svc_take)
    );

    wdog_flags u_flags (
        .clk(clk), .rst_n(rst_n), .cause_short(cause_short),
        .cause_long(cause_long), .cause_por(cause_por), .sw_stb(sw_rst_stb),
        .einit_stb(einit_stb), .ovf(ovf), .svc_take(svc_take), .flags(flags)
    );

    // Compose the read word and drive the reset outputs.
    always_comb begin
        rd_data   = {reload, 2'b00, flags, fsel};
        rst_req   = hold_on;
        rst_out_n = !hold_on;
    end

    // R5: the two reset outputs are always complementary.
    assert_reset_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req != rst_out_n);
endmodule

// File: tb/wdog_supervisor_tb_top.sv
module wdog_supervisor_tb_top;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cause_short = 1'b0, cause_long = 1'b0, cause_por = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        svc_stb = 1'b0, dis_stb = 1'b0, einit_stb = 1'b0, sw_rst_stb = 1'b0;
    logic [15:0] cnt;
    logic        wd_active, rst_req, rst_out_n;

    int errors = 0;
    int checks = 0;
    int edge_idx = 0;

    always #4 clk = ~clk;

    // Count the edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) edge_idx <= 0;
        else        edge_idx <= edge_idx + 1;
    end

    wdog_supervisor #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cause_short(cause_short),
        .cause_long(cause_long), .cause_por(cause_por), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .svc_stb(svc_stb),
        .dis_stb(dis_stb), .einit_stb(einit_stb), .sw_rst_stb(sw_rst_stb),
        .cnt(cnt), .wd_active(wd_active), .rst_req(rst_req),
        .rst_out_n(rst_out_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit tick_at(input int idx, input bit fs);
        return fs ? ((idx % 128) == 127) : ((idx % 2) == 1);
    endfunction

    task automatic do_reset(input logic s, input logic l, input logic p);
        @(negedge clk);
        rst_n = 1'b0; cause_short = s; cause_long = l; cause_por = p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Service at a known edge, then predict the exact overflow edge.
    task automatic run_to_overflow(input logic [7:0] r, input bit fs);
        int s, n, ticks, idx, lowc;
        bit early;
        write_reg({r, 7'b0, fs});
        @(negedge clk);
        s = edge_idx; svc_stb = 1'b1;
        @(negedge clk);
        svc_stb = 1'b0;
        chk("R4 service load", cnt, {r, 8'h00});
        n = 65536 - int'(r) * 256;
        ticks = 0; idx = s + 1; early = 0;
        forever begin
            if (tick_at(idx, fs)) ticks++;
            idx++;
            @(negedge clk);
            if (ticks == n) break;
            if (!rst_out_n) early = 1;
        end
        chk("R3 no early overflow", early, 0);
        chk("R5 window opens", {rst_req, rst_out_n}, 2'b10);
        lowc = 1;
        forever begin
            @(negedge clk);
            if (!rst_out_n && lowc < 100) lowc++;
            else break;
        end
        chk("R5 window length", lowc, HOLD);
        chk("R5 reload after window", cnt, {r, 8'h00});
        chk("R7 flag set by overflow", rd_data[1], 1'b1);
        chk("R5 active after window", wd_active, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c0, s, n, t, e;
        // R1, R8: reset state and captured causes.
        do_reset(1'b1, 1'b0, 1'b1);
        chk("R1 cnt", cnt, 16'h0000);
        chk("R1 outputs", {wd_active, rst_req, rst_out_n}, 3'b101);
        chk("R8 causes in word", rd_data, 16'h0028);
        // R3: fast tick on odd divider values.
        repeat (20) @(negedge clk);
        chk("R3 fast tick count", cnt, 16'd10);
        // R8 software flag, R6 write mask.
        pulse(sw_rst_stb);
        chk("R8 sw flag", rd_data, 16'h002C);
        write_reg(16'hFFFF);
        chk("R6 write mask", rd_data, 16'hFF2D);
        write_reg(16'hFF00);
        chk("R6 select cleared", rd_data, 16'hFF2C);
        // R2: disable inside the start-up window.
        pulse(dis_stb);
        chk("R2 disabled", wd_active, 1'b0);
        c0 = cnt;
        repeat (300) @(negedge clk);
        chk("R2 frozen", cnt, c0);
        pulse(einit_stb);
        chk("R8 einit clears causes", rd_data, 16'hFF00);
        // R2: disable after init is ignored.
        do_reset(1'b0, 1'b1, 1'b0);
        chk("R8 long cause", rd_data, 16'h0010);
        pulse(einit_stb);
        chk("R8 einit clear", rd_data, 16'h0000);
        pulse(dis_stb);
        chk("R2 disable ignored", wd_active, 1'b1);
        c0 = cnt;
        repeat (10) @(negedge clk);
        chk("R2 still counting", (cnt != c0), 1'b1);
        // R3, R4, R5, R7: sweep reloads with the fast tick.
        for (int r = 8'hF8; r <= 8'hFF; r++) run_to_overflow(8'(r), 1'b0);
        // R3: slow tick.
        run_to_overflow(8'hFF, 1'b1);
        // R7: service clears the flag.
        pulse(svc_stb);
        chk("R7 service clears flag", rd_data[1], 1'b0);
        // R4: service on the overflow edge wins.
        write_reg(16'hFF00);
        @(negedge clk);
        s = edge_idx; svc_stb = 1'b1;
        @(negedge clk);
        svc_stb = 1'b0;
        n = 256; t = 0; e = s;
        while (t < n) begin e++; if (tick_at(e, 1'b0)) t++; end
        while (edge_idx != e) @(negedge clk);
        svc_stb = 1'b1;
        @(negedge clk);
        svc_stb = 1'b0;
        chk("R4 service beats overflow", {rst_out_n, cnt}, {1'b1, 16'hFF00});
        // R2: the window reopens after a watchdog reset.
        pulse(einit_stb);
        run_to_overflow(8'hFF, 1'b0);
        pulse(dis_stb);
        chk("R2 disable after watchdog reset", wd_active, 1'b0);
        // R7: hardware reset clears the watchdog flag.
        do_reset(1'b0, 1'b0, 1'b0);
        chk("R7 hw reset clears flag", rd_data, 16'h0000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule